// File: doc/BRIEF.md
# Bus Lock-Up and Inactivity Watchdog

This block sits beside the byte engine of a two-wire management-bus slave and watches the clock and data lines. It runs three timers, each counted in system-clock cycles and set by a parameter. The first measures how long either line stays low for reasons other than the slave's own clock stretch. If that time reaches the lock-up limit, the block aborts the transfer and tells the engine to let go of both lines. The second measures how long the bus shows no activity. If that time reaches the idle limit, the block asks the engine to re-initialise its interface. The third limits how long the slave itself may hold the clock low.

The engine signals three events to the block: a detected start, a detected stop, and the end of the ninth (acknowledge) bit of a byte. It also states whether it wants to stretch. The block answers with the actual clock-hold drive, a window flag that shows when stretching is legal, and three single-cycle strobes: abort, re-initialise and stretch timeout. The real limits are large: 35 ms for lock-up, 25 ms for stretching and 5 s for idle. At a 50 MHz system clock these are 1,750,000, 1,250,000 and 250,000,000 cycles, and they are the defaults. Because the limits are given in system cycles, both the 100 kHz and the 400 kHz bus rates work unchanged. The line inputs are expected to be synchronised to `clk` already.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released with both lines high, `scl_hold`, `stretch_ok`, `stretch_timeout`, `abort_pulse`, `reinit_pulse` and `bus_release` are all 0.
- R2: If a line counts as low for LOCKUP_CYC consecutive clock edges, `abort_pulse` goes high for exactly one cycle after the last of those edges. A line counts as low when `sda_in` is 0, or when `scl_in` is 0 while `scl_hold` is 0. In the same cycle as the abort, `bus_release` rises.
- R3: `bus_release` stays high until an edge samples both lines high, and falls in the cycle after that edge. While it is high, no further abort is raised, no re-initialise is raised, the stretch window is closed and `scl_hold` stays 0 whatever `stretch_req` does.
- R4: Time during which the clock is low only because `scl_hold` drives it low does not count towards the lock-up limit.
- R5: After IDLE_CYC consecutive edges with no activity, `reinit_pulse` goes high for exactly one cycle, and the idle count then starts again from zero.
- R6: Activity is any change of `scl_in` or `sda_in` between two edges, or a `start_det` or `stop_det` strobe. Activity restarts the idle count.
- R7: `stretch_ok` opens in the cycle after an edge that samples `ack_done` or `start_det`. It closes after an edge that samples a rising clock line, after a stretch timeout, or after an abort.
- R8: `scl_hold` equals `stretch_req` while `stretch_ok` is 1 and is 0 otherwise. A request made outside the window has no effect on the clock.
- R9: `scl_hold` is never high for more than STRETCH_CYC consecutive cycles. When that limit is reached, the hold is forced off even if the request stays high, and `stretch_timeout` pulses for one cycle in the first cycle in which the hold is low. A stretch that the engine ends earlier produces no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised clock-line level |
| sda_in | input | 1 | Synchronised data-line level |
| start_det | input | 1 | Start condition seen by the engine (one-cycle strobe) |
| stop_det | input | 1 | Stop condition seen by the engine (one-cycle strobe) |
| ack_done | input | 1 | Ninth (acknowledge) bit of a byte completed (strobe) |
| stretch_req | input | 1 | Engine wants to hold the clock low |
| scl_hold | output | 1 | Drive the clock line low |
| stretch_ok | output | 1 | Stretch window is open |
| stretch_timeout | output | 1 | One-cycle pulse when a stretch was cut off at the limit |
| abort_pulse | output | 1 | One-cycle abort of the current transfer on lock-up |
| reinit_pulse | output | 1 | One-cycle request to re-initialise after idle |
| bus_release | output | 1 | Engine must release both lines until the bus is high again |

## Verification
The bench counts the exact number of edges to each strobe. A timer that is off by one, in either direction, moves the abort, re-initialise or timeout pulse by one cycle and is caught. A clock stretch is made longer than the lock-up limit: a design that counted its own hold as a stuck clock would abort in the middle of that stretch. A toggle and a start strobe are placed inside the idle interval, and a design that ignored either would re-initialise too early. A stretch request is given outside the window, after a clock rise closes the window, and during recovery. While lines are still held low after an abort, the bench checks that no second abort follows and that no hold leaks onto the clock.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic {
        WD_MONITOR = 1'b0,
        WD_RECOVER = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    function automatic logic lines_high(input bus_lines_t l);
        return l.scl && l.sda;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return $clog2(limit) + 1;
    endfunction

endpackage

// File: rtl/bwd_limit_timer.sv
module bwd_limit_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int unsigned CW = bwd_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign hit = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || hit) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bwd_line_monitor.sv
module bwd_line_monitor
    import bwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t now,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       activity,
    output logic       scl_rise
);
    bus_lines_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '{scl: 1'b1, sda: 1'b1};
        else     prev <= now;
    end

    assign activity = (now != prev) || start_det || stop_det;
    assign scl_rise = !prev.scl && now.scl;
endmodule

// File: rtl/bwd_stretch_guard.sv
module bwd_stretch_guard #(
    parameter int unsigned STRETCH_CYC = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic open_win,
    input  logic scl_rise,
    input  logic stretch_req,
    output logic scl_hold,
    output logic stretch_ok,
    output logic stretch_timeout
);
    logic win;
    logic limit_hit;

    assign stretch_ok = win && enable;
    assign scl_hold   = stretch_req && stretch_ok;

    bwd_limit_timer #(.LIMIT(STRETCH_CYC)) u_hold_timer (
        .clk (clk),
        .rst (rst),
        .run (scl_hold),
        .hit (limit_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win             <= 1'b0;
            stretch_timeout <= 1'b0;
        end else begin
            stretch_timeout <= limit_hit;
            if (!enable || limit_hit) win <= 1'b0;
            else if (open_win)        win <= 1'b1;
            else if (scl_rise)        win <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import bwd_pkg::*;
#(
    parameter int unsigned LOCKUP_CYC  = 1750000,
    parameter int unsigned STRETCH_CYC = 1250000,
    parameter int unsigned IDLE_CYC    = 250000000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_det,
    input  logic stop_det,
    input  logic ack_done,
    input  logic stretch_req,
    output logic scl_hold,
    output logic stretch_ok,
    output logic stretch_timeout,
    output logic abort_pulse,
    output logic reinit_pulse,
    output logic bus_release
);
    wd_state_e  state;
    bus_lines_t lines;
    logic       activity, scl_rise;
    logic       monitoring;
    logic       stuck_low, lock_hit, idle_hit;

    assign lines       = '{scl: scl_in, sda: sda_in};
    assign monitoring  = (state == WD_MONITOR);
    assign bus_release = (state == WD_RECOVER);

    bwd_line_monitor u_lines (
        .clk       (clk),
        .rst       (rst),
        .now       (lines),
        .start_det (start_det),
        .stop_det  (stop_det),
        .activity  (activity),
        .scl_rise  (scl_rise)
    );

    bwd_stretch_guard #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk             (clk),
        .rst             (rst),
        .enable          (monitoring),
        .open_win        (ack_done || start_det),
        .scl_rise        (scl_rise),
        .stretch_req     (stretch_req),
        .scl_hold        (scl_hold),
        .stretch_ok      (stretch_ok),
        .stretch_timeout (stretch_timeout)
    );

    // own stretch is excluded from the stuck-line measure
    assign stuck_low = !sda_in || (!scl_in && !scl_hold);

    bwd_limit_timer #(.LIMIT(LOCKUP_CYC)) u_lock_timer (
        .clk (clk),
        .rst (rst),
        .run (monitoring && stuck_low),
        .hit (lock_hit)
    );

    bwd_limit_timer #(.LIMIT(IDLE_CYC)) u_idle_timer (
        .clk (clk),
        .rst (rst),
        .run (monitoring && !activity),
        .hit (idle_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= WD_MONITOR;
            abort_pulse  <= 1'b0;
            reinit_pulse <= 1'b0;
        end else begin
            abort_pulse  <= lock_hit;
            reinit_pulse <= idle_hit && !lock_hit;
            case (state)
                WD_MONITOR: if (lock_hit)           state <= WD_RECOVER;
                WD_RECOVER: if (lines_high(lines))  state <= WD_MONITOR;
                default:                            state <= WD_MONITOR;
            endcase
        end
    end
endmodule

// File: rtl/bus_watchdog_chk.sv
module bus_watchdog_chk #(
    parameter int unsigned STRETCH_CYC = 16
) (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_in,
    input logic start_det,
    input logic ack_done,
    input logic scl_hold,
    input logic stretch_ok,
    input logic stretch_timeout,
    input logic abort_pulse,
    input logic reinit_pulse,
    input logic bus_release
);
    logic [31:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst)           hold_run <= '0;
        else if (scl_hold) hold_run <= hold_run + 1;
        else               hold_run <= '0;
    end

    p_abort_single_r2: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);
    p_abort_release_r2: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> bus_release);
    p_release_no_hold_r3: assert property (@(posedge clk) disable iff (rst)
        bus_release |-> !scl_hold);
    p_release_exit_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_release) |-> $past(scl_in && sda_in));
    p_release_no_reinit_r3: assert property (@(posedge clk) disable iff (rst)
        reinit_pulse |-> !bus_release);
    p_reinit_single_r5: assert property (@(posedge clk) disable iff (rst)
        reinit_pulse |=> !reinit_pulse);
    p_window_open_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(stretch_ok) |-> $past(ack_done || start_det));
    p_hold_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        scl_hold |-> stretch_ok);
    p_hold_limit_r9: assert property (@(posedge clk) disable iff (rst)
        hold_run <= STRETCH_CYC);
    p_timeout_released_r9: assert property (@(posedge clk) disable iff (rst)
        stretch_timeout |-> !scl_hold);
endmodule

bind bus_watchdog bus_watchdog_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .scl_in          (scl_in),
    .sda_in          (sda_in),
    .start_det       (start_det),
    .ack_done        (ack_done),
    .scl_hold        (scl_hold),
    .stretch_ok      (stretch_ok),
    .stretch_timeout (stretch_timeout),
    .abort_pulse     (abort_pulse),
    .reinit_pulse    (reinit_pulse),
    .bus_release     (bus_release)
);

// File: tb/bus_watchdog_tb.sv
module bus_watchdog_tb;
    localparam int LOCK = 40;
    localparam int STR  = 60;
    localparam int IDLE = 120;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic start_det = 1'b0, stop_det = 1'b0, ack_done = 1'b0, stretch_req = 1'b0;
    logic scl_in;
    logic scl_hold, stretch_ok, stretch_timeout, abort_pulse, reinit_pulse, bus_release;

    int checks = 0;
    int errors = 0;
    int aborts_seen = 0;
    int timeouts_seen = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    assign scl_in = scl_m & ~scl_hold;

    bus_watchdog #(.LOCKUP_CYC(LOCK), .STRETCH_CYC(STR), .IDLE_CYC(IDLE)) u_dut (
        .clk (clk), .rst (rst), .scl_in (scl_in), .sda_in (sda_m),
        .start_det (start_det), .stop_det (stop_det), .ack_done (ack_done),
        .stretch_req (stretch_req), .scl_hold (scl_hold), .stretch_ok (stretch_ok),
        .stretch_timeout (stretch_timeout), .abort_pulse (abort_pulse),
        .reinit_pulse (reinit_pulse), .bus_release (bus_release)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (abort_pulse)     aborts_seen   <= aborts_seen + 1;
        if (stretch_timeout) timeouts_seen <= timeouts_seen + 1;
    end

    always @(negedge clk) begin
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // edges passed until the chosen output is seen high at a falling edge
    task automatic count_until(input int which, input int maxn, output int n);
        n = 0;
        for (int i = 0; i < maxn; i++) begin
            @(negedge clk);
            n = n + 1;
            if ((which == 0 && reinit_pulse) || (which == 1 && abort_pulse) ||
                (which == 2 && stretch_timeout)) return;
        end
        n = -1;
    endtask

    task automatic do_reset();
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        start_det = 1'b0; stop_det = 1'b0; ack_done = 1'b0; stretch_req = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic t_reset_r1();
        rst = 1'b1;
        cyc(2);
        chk("R1", "outputs in reset",
            {scl_hold, stretch_ok, stretch_timeout, abort_pulse, reinit_pulse, bus_release}, 0);
        do_reset();
        cyc(1);
        chk("R1", "outputs after reset",
            {scl_hold, stretch_ok, stretch_timeout, abort_pulse, reinit_pulse, bus_release}, 0);
    endtask

    task automatic t_idle_r5_r6();
        int n;
        do_reset();
        count_until(0, 400, n);
        chk("R5", "edges to reinit from reset", n, IDLE);
        cyc(1);
        chk("R5", "reinit single cycle", reinit_pulse, 0);
        count_until(0, 400, n);
        chk("R5", "reinit repeats after a new interval", n, IDLE - 1);
        // toggle the clock line mid-interval
        cyc(60);
        scl_m = 1'b0; cyc(1); scl_m = 1'b1;
        count_until(0, 400, n);
        chk("R6", "line edge restarts idle count", n, IDLE + 1);
        // start strobe mid-interval
        cyc(50);
        start_det = 1'b1; cyc(1); start_det = 1'b0;
        count_until(0, 400, n);
        chk("R6", "start strobe restarts idle count", n, IDLE);
        cyc(30);
        stop_det = 1'b1; cyc(1); stop_det = 1'b0;
        count_until(0, 400, n);
        chk("R6", "stop strobe restarts idle count", n, IDLE);
    endtask

    task automatic t_lockup_r2_r3();
        int n, a0;
        do_reset();
        sda_m = 1'b0;
        count_until(1, 400, n);
        chk("R2", "edges to abort with data low", n, LOCK);
        chk("R2", "release with abort", bus_release, 1);
        cyc(1);
        chk("R2", "abort single cycle", abort_pulse, 0);
        a0 = aborts_seen;
        ack_done = 1'b1; stretch_req = 1'b1;
        cyc(1); ack_done = 1'b0;
        for (int i = 0; i < 3 * LOCK; i++) begin
            @(negedge clk);
            if (scl_hold || stretch_ok || !bus_release || reinit_pulse) break;
        end
        chk("R3", "no hold or window while released", {scl_hold, stretch_ok}, 0);
        chk("R3", "release held while data low", bus_release, 1);
        chk("R3", "no further abort while released", aborts_seen - a0, 0);
        stretch_req = 1'b0;
        sda_m = 1'b1;
        cyc(1);
        chk("R3", "release drops once lines high", bus_release, 0);
        // clock-line variant
        scl_m = 1'b0;
        count_until(1, 400, n);
        chk("R2", "edges to abort with clock low", n, LOCK);
        scl_m = 1'b1;
        cyc(1);
        chk("R3", "release drops after clock high", bus_release, 0);
    endtask

    task automatic t_stretch_r4_r7_r9();
        int n, a0;
        do_reset();
        a0 = aborts_seen;
        scl_m = 1'b1;
        ack_done = 1'b1; stretch_req = 1'b1;
        cyc(1);
        ack_done = 1'b0;
        chk("R7", "window opens after ack", stretch_ok, 1);
        chk("R8", "hold follows request", scl_hold, 1);
        count_until(2, 400, n);
        chk("R9", "cycles to stretch timeout", n, STR);
        chk("R9", "hold forced off at timeout", scl_hold, 0);
        chk("R4", "own stretch not seen as lock-up", aborts_seen - a0, 0);
        cyc(1);
        chk("R9", "timeout single cycle", stretch_timeout, 0);
        chk("R9", "hold stays off with request high", scl_hold, 0);
        chk("R7", "window closed after timeout", stretch_ok, 0);
        stretch_req = 1'b0;
        // short stretch ended by the engine
        a0 = timeouts_seen;
        start_det = 1'b1; stretch_req = 1'b1;
        cyc(1);
        start_det = 1'b0;
        chk("R7", "window opens after start", stretch_ok, 1);
        cyc(10);
        stretch_req = 1'b0;
        cyc(STR + 5);
        chk("R9", "early release gives no timeout", timeouts_seen - a0, 0);
    endtask

    task automatic t_window_r7_r8();
        do_reset();
        stretch_req = 1'b1;
        cyc(5);
        chk("R8", "request outside window ignored", {scl_hold, scl_in}, 1);
        stretch_req = 1'b0;
        start_det = 1'b1; cyc(1); start_det = 1'b0;
        chk("R7", "window open after start", stretch_ok, 1);
        scl_m = 1'b0; cyc(1);
        scl_m = 1'b1; cyc(1);
        chk("R7", "window closed by clock rise", stretch_ok, 0);
        stretch_req = 1'b1;
        cyc(2);
        chk("R8", "request after window closed ignored", {scl_hold, scl_in}, 1);
        stretch_req = 1'b0;
    endtask

    initial begin
        t_reset_r1();
        t_idle_r5_r6();
        t_lockup_r2_r3();
        t_stretch_r4_r7_r9();
        t_window_r7_r8();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule